// File: doc/BRIEF.md
# Two-Wire Control Target with Threshold Programming Strobes

This block is a two-wire serial (I2C) target that runs entirely in the system clock domain. It samples the bus clock and data lines, finds start and stop conditions, and owns a small bank of 8-bit control registers. The master writes a register by sending the device write address, a register pointer and one or more data bytes. It reads registers by sending a pointer, then a repeated start with the read address, and then clocking data out. The pointer advances after every data byte, in both directions.

Two special writes control an external threshold-programming circuit. When the programming-enable input is high, writing 00h to pointer 01h arms a set-threshold request, and writing 00h to pointer 03h arms a reset-threshold request. The armed request fires as a one-cycle strobe when the stop condition that ends the transaction arrives, but only if programming-enable is still high at that moment. SDA is open-drain: the block only ever pulls the line low, through an output enable.

Top module: `i2c_trip_target`

## Requirements
- R1: After synchronous reset, sda_oe_o is 0, every control register is 00h, and both strobes are 0.
- R2: Until a start condition is seen (SDA falling while SCL is high), bus clocking gets no acknowledge and changes no register. A stop (SDA rising while SCL is high) returns the block to idle.
- R3: The address byte A0h (write) or A1h (read), that is the 7-bit address 50h followed by the R/W bit, is acknowledged. Any other address byte gets no acknowledge, and the block ignores everything until the next start.
- R4: After a write address, the next byte is taken as the register pointer and is acknowledged.
- R5: Each following data byte is acknowledged and stored in register[pointer] when the pointer is below NREG, and then the pointer increments. A data byte sent to a pointer at or above NREG is acknowledged but changes no register. Register i appears on ctrl_regs_o[8*i+7:8*i].
- R6: After a repeated start with the read address, the block shifts out register[pointer], MSB first, each bit valid while SCL is high. A pointer at or above NREG reads as 00h.
- R7: During a read, a master acknowledge moves on to the next register. A master not-acknowledge releases SDA and ends transmission.
- R8: Writing 00h to pointer 01h with prog_en_i high produces exactly one one-cycle pulse on trip_set_o after the following stop, provided prog_en_i is also high when the stop is detected.
- R9: Writing 00h to pointer 03h under the same conditions produces exactly one one-cycle pulse on trip_reset_o.
- R10: No strobe fires if prog_en_i is low when the data byte completes or when the stop is detected, or if the data byte is not 00h. The two strobes are never high together.
- R11: Every acknowledge the block gives holds SDA low through the whole ninth SCL high phase, and SDA is released again after the ninth SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| prog_en_i | input | 1 | Programming enable for the threshold strobes |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| ctrl_regs_o | output | NREG*8 | Flattened control registers |
| trip_set_o | output | 1 | One-cycle set-threshold strobe |
| trip_reset_o | output | 1 | One-cycle reset-threshold strobe |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a start or a stop. They also assume that each SCL level lasts several system clocks longer than the two-flop synchroniser, so that every SCL edge is seen exactly once. The bench drives every bus phase for eight system clocks and moves its inputs one nanosecond after a clock edge. It changes prog_en_i only between bus transactions, or deliberately before a stop, so the gating property always compares against a settled pin value.

// File: rtl/i2c_trip_pkg.sv
package i2c_trip_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;

  localparam logic [7:0] TRIP_SET_PTR = 8'h01;
  localparam logic [7:0] TRIP_CLR_PTR = 8'h03;
  localparam logic [7:0] TRIP_KEY     = 8'h00;
  localparam int         LINE_SCL     = 0;
  localparam int         LINE_SDA     = 1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int N_LINES = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] lvl_o,
  output logic [N_LINES-1:0] lvl_q_o,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw_i[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign lvl_o[g]   = chain[STAGES-1];
    assign lvl_q_o[g] = last;
    assign rise_o[g]  = chain[STAGES-1] & ~last;
    assign fall_o[g]  = ~chain[STAGES-1] & last;
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NREG*DW-1:0] flat_o
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat_o[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/i2c_trip_target.sv
module i2c_trip_target
  import i2c_trip_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         NREG        = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            prog_en_i,
  output logic            sda_oe_o,
  output logic [NREG*8-1:0] ctrl_regs_o,
  output logic            trip_set_o,
  output logic            trip_reset_o
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [1:0] lvl, lvl_q, rise, fall;
  logic       scl_rise, scl_fall, sda_s, start_c, stop_c;
  tgt_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr;
  logic       dir_rd, acked, arm_set, arm_clr;
  logic       in_range, we;
  logic [7:0] rdata, rd_byte;

  i2c_line_sync #(.N_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i({sda_i, scl_i}),
    .lvl_o(lvl), .lvl_q_o(lvl_q), .rise_o(rise), .fall_o(fall)
  );

  assign scl_rise = rise[LINE_SCL];
  assign scl_fall = fall[LINE_SCL];
  assign sda_s    = lvl[LINE_SDA];
  assign start_c  = fall[LINE_SDA] & lvl[LINE_SCL] & lvl_q[LINE_SCL];
  assign stop_c   = rise[LINE_SDA] & lvl[LINE_SCL] & lvl_q[LINE_SCL];

  assign in_range = (ptr < 8'(NREG));
  assign rd_byte  = in_range ? rdata : 8'h00;
  assign we       = (state == ST_WR) && !start_c && !stop_c && !scl_rise &&
                    scl_fall && (bitcnt == 4'd8) && in_range;

  i2c_reg_bank #(.NREG(NREG), .DW(8)) u_bank (
    .clk(clk), .rst(rst), .we_i(we), .waddr_i(ptr[AW-1:0]), .wdata_i(shreg),
    .raddr_i(ptr[AW-1:0]), .rdata_o(rdata), .flat_o(ctrl_regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bitcnt       <= '0;
      shreg        <= '0;
      ptr          <= '0;
      dir_rd       <= 1'b0;
      acked        <= 1'b0;
      arm_set      <= 1'b0;
      arm_clr      <= 1'b0;
      sda_oe_o     <= 1'b0;
      trip_set_o   <= 1'b0;
      trip_reset_o <= 1'b0;
    end else begin
      trip_set_o   <= 1'b0;
      trip_reset_o <= 1'b0;
      if (start_c) begin
        state    <= ST_DEV;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
        arm_set  <= 1'b0;
        arm_clr  <= 1'b0;
      end else if (stop_c) begin
        state        <= ST_IDLE;
        sda_oe_o     <= 1'b0;
        trip_set_o   <= arm_set & prog_en_i;
        trip_reset_o <= arm_clr & prog_en_i;
        arm_set      <= 1'b0;
        arm_clr      <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_PTR, ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe_o <= 1'b1;
                  dir_rd   <= shreg[0];
                  state    <= ST_DEV_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                sda_oe_o <= 1'b1;
                ptr      <= shreg;
                state    <= ST_PTR_ACK;
              end else begin
                sda_oe_o <= 1'b1;
                arm_set  <= prog_en_i && ptr == TRIP_SET_PTR && shreg == TRIP_KEY;
                arm_clr  <= prog_en_i && ptr == TRIP_CLR_PTR && shreg == TRIP_KEY;
                ptr      <= ptr + 8'd1;
                state    <= ST_WR_ACK;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (dir_rd) begin
              shreg    <= rd_byte;
              sda_oe_o <= ~rd_byte[7];
              state    <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ST_PTR;
            end
          end
          ST_PTR_ACK, ST_WR_ACK: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            state    <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe_o <= 1'b0;
              ptr      <= ptr + 8'd1;
              state    <= ST_RD_ACK;
            end else begin
              sda_oe_o <= ~shreg[6];
              shreg    <= {shreg[6:0], 1'b0};
              bitcnt   <= bitcnt + 4'd1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              acked <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (acked) begin
                shreg    <= rd_byte;
                sda_oe_o <= ~rd_byte[7];
                state    <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_trip_target_chk.sv
module i2c_trip_target_chk #(
  parameter int NREG = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_en_i,
  input logic              sda_oe_o,
  input logic [NREG*8-1:0] ctrl_regs_o,
  input logic              trip_set_o,
  input logic              trip_reset_o
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe_o && !trip_set_o && !trip_reset_o));

  p_write_with_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_regs_o != $past(ctrl_regs_o)) |-> (sda_oe_o && !$past(sda_oe_o)));

  p_set_single_r8: assert property (@(posedge clk) disable iff (rst)
    trip_set_o |=> !trip_set_o);

  p_reset_single_r9: assert property (@(posedge clk) disable iff (rst)
    trip_reset_o |=> !trip_reset_o);

  p_strobe_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (trip_set_o || trip_reset_o) |-> $past(prog_en_i));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(trip_set_o && trip_reset_o));
endmodule

bind i2c_trip_target i2c_trip_target_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .prog_en_i(prog_en_i), .sda_oe_o(sda_oe_o),
  .ctrl_regs_o(ctrl_regs_o), .trip_set_o(trip_set_o), .trip_reset_o(trip_reset_o)
);

// File: tb/i2c_trip_target_bench.sv
`timescale 1ns/1ps
module i2c_trip_target_bench;
  localparam int NREG = 4;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic prog_en = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] regs;
  logic trip_set, trip_reset;

  int checks = 0;
  int failures = 0;
  int n_set = 0;
  int n_rst = 0;
  logic [7:0] exp_regs [NREG];

  always #2.5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_trip_target #(.NREG(NREG)) u_i2c_trip_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .prog_en_i(prog_en),
    .sda_oe_o(sda_oe), .ctrl_regs_o(regs), .trip_set_o(trip_set),
    .trip_reset_o(trip_reset)
  );

  always @(posedge clk) begin
    if (trip_set) n_set <= n_set + 1;
    if (trip_reset) n_rst <= n_rst + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b0; wq(Q);
    scl = 1'b0;     wq(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b1; wq(2*Q);
  endtask

  // Sends one byte and returns whether SDA was held low over the whole
  // ninth high phase, plus whether SDA was released after that clock.
  task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
    bit lo_a, lo_b;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq(Q);
      scl = 1'b1;     wq(2*Q);
      scl = 1'b0;     wq(Q);
    end
    sda_drv = 1'b1; wq(Q);
    scl = 1'b1;     wq(1);
    lo_a = (sda_line == 1'b0);
    wq(2*Q - 2);
    lo_b = (sda_line == 1'b0);
    wq(1);
    scl = 1'b0;     wq(Q);
    ack = lo_a && lo_b;
    rel = !sda_oe;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      scl = 1'b0;
    end
    wq(Q);
    sda_drv = give_ack ? 1'b0 : 1'b1;
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
    sda_drv = 1'b1;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[8*i +: 8] == exp_regs[i], req, regs[8*i +: 8], exp_regs[i]);
  endtask

  task automatic write_seq(input logic [7:0] p, input logic [7:0] d,
                           input string req);
    bit a, r;
    bus_start();
    send_byte(8'hA0, a, r); chk(a, {req, " dev ack"}, a, 1);
    send_byte(p, a, r);     chk(a, {req, " ptr ack"}, a, 1);
    send_byte(d, a, r);     chk(a && r, {req, " data ack R11"}, {a, r}, 2'b11);
    if (p < NREG) exp_regs[p] = d;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(trip_set == 1'b0 && trip_reset == 1'b0, "R1 strobes",
        {trip_set, trip_reset}, 0);
    check_regs("R1 regs");
  endtask

  task automatic t_no_start();
    bit a, r;
    scl = 1'b0; wq(Q);
    send_byte(8'hA0, a, r);
    chk(!a, "R2 no ack before start", a, 0);
    send_byte(8'h02, a, r);
    send_byte(8'h77, a, r);
    chk(!a, "R2 data ignored", a, 0);
    scl = 1'b1; wq(Q);
    check_regs("R2 regs untouched");
  endtask

  task automatic t_wrong_addr();
    bit a, r;
    bus_start();
    send_byte(8'hA2, a, r); chk(!a, "R3 wrong addr nack", a, 0);
    send_byte(8'h01, a, r); chk(!a, "R3 ignored until start", a, 0);
    send_byte(8'h55, a, r); chk(!a, "R3 ignored data", a, 0);
    bus_stop();
    check_regs("R3 regs untouched");
  endtask

  task automatic t_write();
    bit a, r;
    write_seq(8'h02, 8'h5A, "R4");
    send_byte(8'hC3, a, r); chk(a && r, "R5 second byte ack R11", {a, r}, 2'b11);
    exp_regs[3] = 8'hC3;
    bus_stop();
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
    check_regs("R5 write autoinc");
    write_seq(8'h00, 8'h81, "R5");
    bus_stop();
    check_regs("R5 reg0");
  endtask

  task automatic t_random_read();
    bit a, r;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, a, r); chk(a, "R3 write addr ack", a, 1);
    send_byte(8'h02, a, r); chk(a, "R4 ptr ack", a, 1);
    bus_start();
    send_byte(8'hA1, a, r); chk(a, "R3 read addr ack", a, 1);
    recv_byte(1'b1, d);     chk(d == exp_regs[2], "R6 read reg2", d, exp_regs[2]);
    recv_byte(1'b1, d);     chk(d == exp_regs[3], "R7 ack continues", d, exp_regs[3]);
    recv_byte(1'b0, d);     chk(d == 8'h00, "R6 out of range reads 0", d, 0);
    chk(sda_oe == 1'b0, "R7 nack releases", sda_oe, 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R7 idle after stop", sda_oe, 0);
  endtask

  task automatic t_out_of_range();
    bit a, r;
    logic [7:0] d;
    write_seq(8'h07, 8'h11, "R5 oor");
    bus_stop();
    check_regs("R5 oor no write");
    bus_start();
    send_byte(8'hA1, a, r); chk(a, "R6 current read ack", a, 1);
    recv_byte(1'b0, d);     chk(d == 8'h00, "R6 ptr 8 reads 0", d, 0);
    bus_stop();
  endtask

  task automatic t_trip_set();
    int s0 = n_set, r0 = n_rst;
    prog_en = 1'b1;
    write_seq(8'h01, 8'h00, "R8");
    chk(n_set == s0, "R8 no pulse before stop", n_set - s0, 0);
    bus_stop();
    prog_en = 1'b0;
    chk(n_set - s0 == 1, "R8 set pulse count", n_set - s0, 1);
    chk(n_rst == r0, "R8 no reset pulse", n_rst - r0, 0);
    check_regs("R8 regs");
  endtask

  task automatic t_trip_reset();
    int s0 = n_set, r0 = n_rst;
    prog_en = 1'b1;
    write_seq(8'h03, 8'h00, "R9");
    bus_stop();
    prog_en = 1'b0;
    chk(n_rst - r0 == 1, "R9 reset pulse count", n_rst - r0, 1);
    chk(n_set == s0, "R9 no set pulse", n_set - s0, 0);
  endtask

  task automatic t_no_trip();
    int s0 = n_set, r0 = n_rst;
    write_seq(8'h01, 8'h00, "R10 pin low");
    bus_stop();
    chk(n_set == s0, "R10 pin low no pulse", n_set - s0, 0);
    prog_en = 1'b1;
    write_seq(8'h01, 8'h05, "R10 data");
    bus_stop();
    chk(n_set == s0, "R10 nonzero data no pulse", n_set - s0, 0);
    write_seq(8'h03, 8'h00, "R10 drop");
    prog_en = 1'b0;
    bus_stop();
    chk(n_rst == r0, "R10 pin dropped before stop", n_rst - r0, 0);
    check_regs("R10 regs");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    wq(4);
    rst = 1'b0;
    wq(4);
    t_reset();
    t_no_start();
    t_wrong_addr();
    t_write();
    t_random_read();
    t_out_of_range();
    t_trip_set();
    t_trip_reset();
    t_no_trip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule